// File: doc/BRIEF.md
# Keyed Plug-and-Play Configuration Port

This block is the configuration front end of a multi-function I/O controller. The host sees two byte-wide I/O locations. The lower one is an index port and the upper one is a data port. Behind them are a small set of chip-wide registers and a bank of setup registers for each logical device. Each bank holds an activate bit, I/O base bytes, interrupt and DMA selections, and an option byte. The block drives an enable line and a power-down line for each logical device, a chip low-power line, and the parallel-port mode bit.

All configuration accesses are refused until firmware writes the unlock key to the index port: the byte 0x87 twice in a row. Writing 0xAA to the index port locks the interface again. While the interface is open, firmware writes a register number to the index port and then reads or writes that register through the data port. Register 0x07 holds the logical device number. That number decides which device bank appears at register numbers 0x30 and above. Registers below 0x30 are shared by all banks.

Top module: `pnp_cfg_port`

## Requirements
- R1: After reset the interface is locked, the device selector is 0, every device is inactive, and all power-down bits are 0. So `dev_enable`, `dev_pwrdn`, `chip_lowpwr` and `lpt_ecp_mode` are all 0.
- R2: The interface opens only after two consecutive index-port writes of 0x87. Any other index-port byte between them cancels the key, and two fresh 0x87 writes are then needed.
- R3: An index-port write of 0xAA while open locks the interface. While locked, data-port writes change nothing, and data-port reads return 0xFF.
- R4: While open, an index-port read returns the last register number written. While locked, it returns 0xFF.
- R5: Register 0x20 reads 0x97 and register 0x21 reads the revision parameter (default 0x73). Writes to both are ignored.
- R6: Register 0x22 holds power-down bits at positions 0, 3, 4 and 5. These drive `dev_pwrdn` of logical devices 0, 1, 2 and 3 respectively. The other bit positions read 0.
- R7: Bit 0 of register 0x23 drives `chip_lowpwr` and reads back. The other bits of 0x23 read 0.
- R8: Register 0x07 selects the logical device. Each device's bank registers keep their own values, independent of the other devices.
- R9: In a bank, these registers read back as written:
  - bit 0 of 0x30 (activate);
  - 0x60 to 0x65 (three I/O base high/low byte pairs);
  - 0x70 and 0x72 (interrupt numbers);
  - 0x74 (DMA channel);
  - 0xF0 (option).
  Other bank register numbers read 0x00 and ignore writes.
- R10: With a selector of 11 or more, bank writes are ignored and bank reads return 0x00.
- R11: `dev_enable[d]` is 1 exactly when device d is active, its power-down bit is 0, and chip power-down is 0.
- R12: `lpt_ecp_mode` follows bit 1 of register 0xF0 in the bank of logical device 1 (the parallel port): 1 selects extended-capabilities mode, 0 selects standard mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host write strobe, one cycle per byte |
| io_rd | input | 1 | Host read strobe |
| io_port_sel | input | 1 | 0 selects the index port, 1 selects the data port |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte for the selected port (combinational) |
| dev_enable | output | NUM_DEV | Per-device enable |
| dev_pwrdn | output | NUM_DEV | Per-device power-down |
| chip_lowpwr | output | 1 | Whole-chip power-down |
| lpt_ecp_mode | output | 1 | Parallel port extended-capabilities mode |

## Verification
A key state machine in the wrong state shows up on the very next read strobe: a locked port returns 0xFF, and an open one returns the stored index. A wrong selector or a corrupted bank register shows up as a wrong data-port byte in the same cycle as the read, because reads are combinational. Enable gating is checked at the output pins one cycle after each write that could change it. An enable-gating fault is therefore visible no later than the cycle after the write that caused it.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;

  localparam logic [7:0] KEY_BYTE  = 8'h87;
  localparam logic [7:0] EXIT_BYTE = 8'hAA;
  localparam logic [7:0] IDLE_BYTE = 8'hFF;

  localparam logic [7:0] IX_LDN     = 8'h07;
  localparam logic [7:0] IX_ID      = 8'h20;
  localparam logic [7:0] IX_REV     = 8'h21;
  localparam logic [7:0] IX_PD      = 8'h22;
  localparam logic [7:0] IX_CHIPPD  = 8'h23;
  localparam logic [7:0] IX_BANK_LO = 8'h30;
  localparam logic [7:0] IX_ACT     = 8'h30;
  localparam logic [7:0] IX_IOB0    = 8'h60;
  localparam logic [7:0] IX_IRQ0    = 8'h70;
  localparam logic [7:0] IX_IRQ1    = 8'h72;
  localparam logic [7:0] IX_DMA     = 8'h74;
  localparam logic [7:0] IX_OPT     = 8'h F0;

  localparam int IOB_BYTES = 6;

  localparam logic [7:0] PD_MASK = 8'h39;

  typedef enum logic [1:0] {
    KS_LOCKED = 2'd0,
    KS_HALF   = 2'd1,
    KS_OPEN   = 2'd2
  } key_state_t;

  // Bit of the power-down register that belongs to logical device d, or -1.
  function automatic int pd_bit_for_dev(input int d);
    case (d)
      0: return 0;
      1: return 3;
      2: return 4;
      3: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic is_bank_index(input logic [7:0] ix);
    return ix >= IX_BANK_LO;
  endfunction

  function automatic logic is_iob_index(input logic [7:0] ix);
    return (ix >= IX_IOB0) && (ix < IX_IOB0 + 8'(IOB_BYTES));
  endfunction

  function automatic logic dev_on(input logic act, input logic pd, input logic chip_pd);
    return act & ~pd & ~chip_pd;
  endfunction

endpackage

// File: rtl/pnp_key_fsm.sv
module pnp_key_fsm
  import pnp_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       io_wr,
  input  logic       io_rd,
  input  logic       io_port_sel,
  input  logic [7:0] io_wdata,
  output logic       cfg_open,
  output logic [7:0] cur_index,
  output logic       data_wr_evt,
  output logic       data_rd_evt
);

  key_state_t state_q, state_d;
  logic [7:0] index_q;
  logic       ix_wr;

  assign ix_wr = io_wr && !io_port_sel;

  always_comb begin
    state_d = state_q;
    if (ix_wr) begin
      case (state_q)
        KS_LOCKED: state_d = (io_wdata == KEY_BYTE) ? KS_HALF : KS_LOCKED;
        KS_HALF:   state_d = (io_wdata == KEY_BYTE) ? KS_OPEN : KS_LOCKED;
        KS_OPEN:   state_d = (io_wdata == EXIT_BYTE) ? KS_LOCKED : KS_OPEN;
        default:   state_d = KS_LOCKED;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= KS_LOCKED;
      index_q <= 8'h00;
    end else begin
      state_q <= state_d;
      if (ix_wr && state_q == KS_OPEN && io_wdata != EXIT_BYTE)
        index_q <= io_wdata;
    end
  end

  assign cfg_open    = (state_q == KS_OPEN);
  assign cur_index   = index_q;
  assign data_wr_evt = cfg_open && io_wr && io_port_sel;
  assign data_rd_evt = cfg_open && io_rd && io_port_sel;

endmodule

// File: rtl/pnp_global_regs.sv
module pnp_global_regs
  import pnp_cfg_pkg::*;
#(
  parameter logic [7:0] DEV_ID  = 8'h97,
  parameter logic [7:0] DEV_REV = 8'h73
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_evt,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  output logic [7:0] ldn,
  output logic [7:0] pd_bits,
  output logic       chip_pd,
  output logic [7:0] rdata
);

  logic [7:0] ldn_q;
  logic [7:0] pd_q;
  logic       chip_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldn_q  <= 8'h00;
      pd_q   <= 8'h00;
      chip_q <= 1'b0;
    end else if (wr_evt) begin
      case (index)
        IX_LDN:    ldn_q  <= wdata;
        IX_PD:     pd_q   <= wdata & PD_MASK;
        IX_CHIPPD: chip_q <= wdata[0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (index)
      IX_LDN:    rdata = ldn_q;
      IX_ID:     rdata = DEV_ID;
      IX_REV:    rdata = DEV_REV;
      IX_PD:     rdata = pd_q;
      IX_CHIPPD: rdata = {7'b0, chip_q};
      default:   rdata = 8'h00;
    endcase
  end

  assign ldn     = ldn_q;
  assign pd_bits = pd_q;
  assign chip_pd = chip_q;

endmodule

// File: rtl/pnp_dev_bank.sv
module pnp_dev_bank
  import pnp_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] index,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       active,
  output logic [7:0] option
);

  logic       act_q;
  logic [7:0] iob_q [IOB_BYTES];
  logic [7:0] irq0_q, irq1_q, dma_q, opt_q;
  logic [2:0] iob_sel;

  assign iob_sel = 3'(index - IX_IOB0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      irq0_q <= 8'h00;
      irq1_q <= 8'h00;
      dma_q  <= 8'h00;
      opt_q  <= 8'h00;
      for (int k = 0; k < IOB_BYTES; k++) iob_q[k] <= 8'h00;
    end else if (wr_en) begin
      if (index == IX_ACT)  act_q  <= wdata[0];
      if (index == IX_IRQ0) irq0_q <= wdata;
      if (index == IX_IRQ1) irq1_q <= wdata;
      if (index == IX_DMA)  dma_q  <= wdata;
      if (index == IX_OPT)  opt_q  <= wdata;
      if (is_iob_index(index)) iob_q[iob_sel] <= wdata;
    end
  end

  always_comb begin
    rdata = 8'h00;
    if (index == IX_ACT)  rdata = {7'b0, act_q};
    if (index == IX_IRQ0) rdata = irq0_q;
    if (index == IX_IRQ1) rdata = irq1_q;
    if (index == IX_DMA)  rdata = dma_q;
    if (index == IX_OPT)  rdata = opt_q;
    if (is_iob_index(index)) rdata = iob_q[iob_sel];
  end

  assign active = act_q;
  assign option = opt_q;

endmodule

// File: rtl/pnp_cfg_port.sv
module pnp_cfg_port
  import pnp_cfg_pkg::*;
#(
  parameter int         NUM_DEV = 11,
  parameter int         LPT_LDN = 1,
  parameter logic [7:0] DEV_ID  = 8'h97,
  parameter logic [7:0] DEV_REV = 8'h73
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               io_wr,
  input  logic               io_rd,
  input  logic               io_port_sel,
  input  logic [7:0]         io_wdata,
  output logic [7:0]         io_rdata,
  output logic [NUM_DEV-1:0] dev_enable,
  output logic [NUM_DEV-1:0] dev_pwrdn,
  output logic               chip_lowpwr,
  output logic               lpt_ecp_mode
);

  logic       cfg_open;
  logic [7:0] cur_index;
  logic       data_wr_evt;
  logic       data_rd_evt;
  logic [7:0] ldn;
  logic [7:0] pd_bits;
  logic       chip_pd;
  logic [7:0] glob_rdata;
  logic       bank_access;
  logic       glob_wr;

  logic [7:0] bank_rdata [NUM_DEV];
  logic [7:0] bank_opt   [NUM_DEV];
  logic [NUM_DEV-1:0] bank_act;
  logic [7:0] sel_bank_rdata;

  pnp_key_fsm key_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_wr       (io_wr),
    .io_rd       (io_rd),
    .io_port_sel (io_port_sel),
    .io_wdata    (io_wdata),
    .cfg_open    (cfg_open),
    .cur_index   (cur_index),
    .data_wr_evt (data_wr_evt),
    .data_rd_evt (data_rd_evt)
  );

  assign bank_access = is_bank_index(cur_index);
  assign glob_wr     = data_wr_evt && !bank_access;

  pnp_global_regs #(.DEV_ID(DEV_ID), .DEV_REV(DEV_REV)) glob_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_evt  (glob_wr),
    .index   (cur_index),
    .wdata   (io_wdata),
    .ldn     (ldn),
    .pd_bits (pd_bits),
    .chip_pd (chip_pd),
    .rdata   (glob_rdata)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    localparam int PB = pd_bit_for_dev(d);
    logic bank_wr;
    assign bank_wr = data_wr_evt && bank_access && (ldn == 8'(d));

    pnp_dev_bank bank_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_wr),
      .index  (cur_index),
      .wdata  (io_wdata),
      .rdata  (bank_rdata[d]),
      .active (bank_act[d]),
      .option (bank_opt[d])
    );

    if (PB >= 0) begin : g_pd
      assign dev_pwrdn[d] = pd_bits[PB];
    end else begin : g_nopd
      assign dev_pwrdn[d] = 1'b0;
    end

    assign dev_enable[d] = dev_on(bank_act[d], dev_pwrdn[d], chip_pd);
  end

  always_comb begin
    sel_bank_rdata = 8'h00;
    for (int d = 0; d < NUM_DEV; d++)
      if (ldn == 8'(d)) sel_bank_rdata = bank_rdata[d];
  end

  always_comb begin
    if (!cfg_open)        io_rdata = IDLE_BYTE;
    else if (!io_port_sel) io_rdata = cur_index;
    else if (bank_access) io_rdata = sel_bank_rdata;
    else                  io_rdata = glob_rdata;
  end

  assign chip_lowpwr  = chip_pd;
  assign lpt_ecp_mode = bank_opt[LPT_LDN][1];

endmodule

// File: rtl/pnp_cfg_port_chk.sv
module pnp_cfg_port_chk #(
  parameter int NUM_DEV = 11
) (
  input logic               clk,
  input logic               rst_n,
  input logic               io_wr,
  input logic               io_rd,
  input logic               io_port_sel,
  input logic [7:0]         io_wdata,
  input logic [7:0]         io_rdata,
  input logic [NUM_DEV-1:0] dev_enable,
  input logic [NUM_DEV-1:0] dev_pwrdn,
  input logic               chip_lowpwr,
  input logic               cfg_open,
  input logic [7:0]         cur_index
);

  AST_ENABLE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_enable & (dev_pwrdn | {NUM_DEV{chip_lowpwr}})) == '0); // R11

  AST_OPEN_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && !io_port_sel && io_wdata == 8'h87)); // R2

  AST_EXIT_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && !io_port_sel && io_wdata == 8'hAA) |=> !cfg_open); // R3

  AST_LOCKED_READS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd) |-> io_rdata == 8'hFF); // R3

  AST_LOCKED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(dev_pwrdn) && $stable(chip_lowpwr) && $stable(dev_enable))); // R3

  AST_ID_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_rd && io_port_sel && cur_index == 8'h20) |-> io_rdata == 8'h97); // R5

endmodule

bind pnp_cfg_port pnp_cfg_port_chk #(.NUM_DEV(NUM_DEV)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .io_wr       (io_wr),
  .io_rd       (io_rd),
  .io_port_sel (io_port_sel),
  .io_wdata    (io_wdata),
  .io_rdata    (io_rdata),
  .dev_enable  (dev_enable),
  .dev_pwrdn   (dev_pwrdn),
  .chip_lowpwr (chip_lowpwr),
  .cfg_open    (cfg_open),
  .cur_index   (cur_index)
);

// File: tb/pnp_cfg_port_tb_top.sv
module pnp_cfg_port_tb_top;

  localparam int N = 11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         io_wr = 1'b0;
  logic         io_rd = 1'b0;
  logic         io_port_sel = 1'b0;
  logic [7:0]   io_wdata = 8'h00;
  logic [7:0]   io_rdata;
  logic [N-1:0] dev_enable;
  logic [N-1:0] dev_pwrdn;
  logic         chip_lowpwr;
  logic         lpt_ecp_mode;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_item_t;

  exp_item_t sb_q[$];

  always #5 clk = ~clk;

  pnp_cfg_port #(.NUM_DEV(N)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_port_sel  (io_port_sel),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .dev_enable   (dev_enable),
    .dev_pwrdn    (dev_pwrdn),
    .chip_lowpwr  (chip_lowpwr),
    .lpt_ecp_mode (lpt_ecp_mode)
  );

  // Monitor: compares every read strobe against the scoreboard queue.
  always @(negedge clk) begin
    if (io_rd) begin
      compared++;
      if (sb_q.size() == 0) begin
        mismatched++;
        $display("FAIL scoreboard: read with no expected item, actual %02h expected none", io_rdata);
      end else begin
        exp_item_t it;
        it = sb_q.pop_front();
        if (io_rdata !== it.exp) begin
          mismatched++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, io_rdata, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic sel, input logic [7:0] d);
    io_wr = 1'b1; io_port_sel = sel; io_wdata = d;
    @(posedge clk); #1;
    io_wr = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] ix, input logic [7:0] d);
    wr(1'b0, ix);
    wr(1'b1, d);
  endtask

  task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
    exp_item_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    io_rd = 1'b1; io_port_sel = sel;
    @(posedge clk); #1;
    io_rd = 1'b0;
  endtask

  task automatic reg_rd(input logic [7:0] ix, input logic [7:0] exp, input string tag);
    wr(1'b0, ix);
    rd(1'b1, exp, tag);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_en(input logic [N-1:0] act, input logic [N-1:0] pd,
                                          input logic chip);
    return chip ? '0 : (act & ~pd);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1 enable", 16'(dev_enable), 16'h0);
    chk("R1 pwrdn", 16'(dev_pwrdn), 16'h0);
    chk("R1 chip/ecp", {14'b0, chip_lowpwr, lpt_ecp_mode}, 16'h0);
    rd(1'b1, 8'hFF, "R1 locked data read");
    rd(1'b0, 8'hFF, "R4 locked index read");

    // R2 key cancelled by a foreign byte
    wr(1'b0, 8'h87); wr(1'b0, 8'h55); wr(1'b0, 8'h87);
    rd(1'b1, 8'hFF, "R2 aborted key stays locked");
    wr(1'b0, 8'h87);
    wr(1'b0, 8'h20);
    rd(1'b0, 8'h20, "R4 index readback");
    rd(1'b1, 8'h97, "R5 id");
    wr(1'b1, 8'h11);
    rd(1'b1, 8'h97, "R5 id after write");
    reg_rd(8'h21, 8'h73, "R5 revision");

    // R6 power-down register
    reg_wr(8'h22, 8'hFF);
    rd(1'b1, 8'h39, "R6 pd readback mask");
    chk("R6 pwrdn map", 16'(dev_pwrdn), 16'h000F);
    wr(1'b1, 8'h08);
    chk("R6 pwrdn lpt only", 16'(dev_pwrdn), 16'h0002);

    // R11 enable gating
    reg_wr(8'h07, 8'h00);
    reg_wr(8'h30, 8'h01);
    chk("R11 dev0 on", 16'(dev_enable), 16'(exp_en(11'h001, 11'h002, 1'b0)));
    reg_wr(8'h07, 8'h01);
    reg_wr(8'h30, 8'h01);
    chk("R11 dev1 held by pd", 16'(dev_enable), 16'(exp_en(11'h003, 11'h002, 1'b0)));
    reg_wr(8'h22, 8'h00);
    chk("R11 dev1 released", 16'(dev_enable), 16'(exp_en(11'h003, 11'h000, 1'b0)));

    // R9 bank registers of device 2
    reg_wr(8'h07, 8'h02);
    reg_wr(8'h60, 8'h12); reg_wr(8'h61, 8'h34); reg_wr(8'h65, 8'hC3);
    reg_wr(8'h70, 8'h05); reg_wr(8'h72, 8'h0B); reg_wr(8'h74, 8'h03);
    reg_wr(8'hF0, 8'h5A); reg_wr(8'h31, 8'h77); reg_wr(8'h30, 8'hFE);
    reg_rd(8'h60, 8'h12, "R9 iob hi");
    reg_rd(8'h61, 8'h34, "R9 iob lo");
    reg_rd(8'h65, 8'hC3, "R9 iob pair 3");
    reg_rd(8'h70, 8'h05, "R9 irq0");
    reg_rd(8'h72, 8'h0B, "R9 irq1");
    reg_rd(8'h74, 8'h03, "R9 dma");
    reg_rd(8'hF0, 8'h5A, "R9 option");
    reg_rd(8'h31, 8'h00, "R9 unused index");
    reg_rd(8'h30, 8'h00, "R9 activate bit0 only");
    chk("R12 ecp untouched by dev2", {15'b0, lpt_ecp_mode}, 16'h0);

    // R8 banks independent
    reg_wr(8'h07, 8'h00);
    reg_rd(8'h60, 8'h00, "R8 dev0 iob untouched");
    reg_rd(8'h30, 8'h01, "R8 dev0 active");
    reg_rd(8'h07, 8'h00, "R8 selector readback");

    // R12 parallel port mode
    reg_wr(8'h07, 8'h01);
    reg_wr(8'hF0, 8'h02);
    chk("R12 ecp on", {15'b0, lpt_ecp_mode}, 16'h1);
    reg_wr(8'hF0, 8'h00);
    chk("R12 ecp off", {15'b0, lpt_ecp_mode}, 16'h0);

    // R10 unimplemented device number
    reg_wr(8'h07, 8'h0B);
    reg_wr(8'h30, 8'h01);
    reg_wr(8'h60, 8'hAB);
    reg_rd(8'h30, 8'h00, "R10 activate read");
    reg_rd(8'h60, 8'h00, "R10 iob read");
    chk("R10 enables unchanged", 16'(dev_enable), 16'h0003);

    // R7 chip power-down
    reg_wr(8'h23, 8'hFF);
    chk("R7 chip lowpwr", {15'b0, chip_lowpwr}, 16'h1);
    chk("R11 chip gating", 16'(dev_enable), 16'(exp_en(11'h003, 11'h000, 1'b1)));
    rd(1'b1, 8'h01, "R7 readback");
    wr(1'b1, 8'h00);
    chk("R11 chip released", 16'(dev_enable), 16'h0003);

    // R3 exit and locked behaviour
    wr(1'b0, 8'hAA);
    rd(1'b1, 8'hFF, "R3 locked data read");
    rd(1'b0, 8'hFF, "R4 locked index read");
    wr(1'b1, 8'h01);
    chk("R3 locked write ignored", {15'b0, chip_lowpwr}, 16'h0);
    wr(1'b0, 8'h87); wr(1'b0, 8'h87);
    reg_rd(8'h23, 8'h00, "R3 register unchanged after relock");
    reg_rd(8'h22, 8'h00, "R3 pd unchanged");

    repeat (2) @(posedge clk);
    #1;
    chk("scoreboard drained", 16'(sb_q.size()), 16'h0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule